// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block is a compact processor datapath. A bank of general registers, an operand latch Y, a result latch Z and a combinational ALU all hang off one shared internal bus. Every register has its own output gate, which places its content on the bus, and its own input gate, which captures the bus value at the clock edge. The block performs one micro-step per clock. An external data port can also drive the bus, so that values can be placed into the registers.

The ALU has two inputs. Its A side is wired permanently to latch Y. Its B side is wired straight to the bus. Because of this, any two-operand operation needs three gated steps. The first step parks one operand in Y. The second step puts the other operand on the bus and captures the ALU result into Z. The third step puts Z on the bus and writes it into the destination register. A plain move needs a single step. A small built-in sequencer runs the three-step sequence by itself from an opcode and three register indices. While it runs, it takes over all the gating.

Top module: `sbus_datapath`

## Requirements
- R1: After reset, every register, Y and Z hold 0, `seq_busy` and `seq_done` are 0, and the bus reads 0 while nothing drives it.
- R2: When `reg_oe[s]` and `reg_ie[d]` are both set in one cycle, register d holds the old content of register s after that clock edge. Every register whose input gate is set loads the bus.
- R3: The bus carries the value of its single active driver: a register, Z (`z_oe`) or the external port (`ext_oe`, `ext_data`). The bus is 0 when there is no driver.
- R4: When more than one of `reg_oe`, `z_oe` and `ext_oe` is active, `bus_conflict` is 1 and the bus reads 0. At that edge no register, no Y and no Z is loaded.
- R5: `y_ie` loads the bus into Y. ALU input A is always Y and ALU input B is always the bus.
- R6: Z changes only on an edge where `z_ie` is set, and it then takes the ALU result. `alu_sel` is one-hot with bit 0 add, bit 1 subtract, bit 2 AND, bit 3 OR, bit 4 NOT, bit 5 XOR. The lowest set bit wins. With no bit set, the ALU passes B through.
- R7: Add gives (A+B) mod 2^W and subtract gives (A-B) mod 2^W. AND, OR and XOR are bitwise on A and B. NOT gives ~B.
- R8: When the block is idle, `seq_start` is accepted together with `seq_op`, `seq_a`, `seq_b` and `seq_dst`. The opcodes are 0 add, 1 sub, 2 AND, 3 OR, 4 NOT, 5 XOR, and 6 or 7 pass B. `seq_busy` is 1 from the edge that accepts the start. Register `seq_dst` receives op(reg[seq_a], reg[seq_b]) on the third edge after acceptance. `seq_done` is 1 for exactly the one cycle that follows that edge.
- R9: While `seq_busy` is 1, all external gating inputs, `ext_oe` and `seq_start` are ignored, and `bus_conflict` stays 0.
- R10: The sequencer destination may equal one or both of the sources. The sources are read before the destination is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_oe | input | NREG | Per-register output gate onto the bus |
| reg_ie | input | NREG | Per-register input gate from the bus |
| y_ie | input | 1 | Load Y from the bus |
| z_oe | input | 1 | Drive Z onto the bus |
| z_ie | input | 1 | Load Z from the ALU |
| alu_sel | input | 6 | One-hot ALU function lines |
| ext_oe | input | 1 | Drive `ext_data` onto the bus |
| ext_data | input | W | External bus value |
| seq_start | input | 1 | Start a three-step operation |
| seq_op | input | 3 | Sequencer opcode |
| seq_a | input | IW | First source index (goes to Y) |
| seq_b | input | IW | Second source index (goes to ALU B) |
| seq_dst | input | IW | Destination index |
| bus | output | W | Current shared bus value |
| bus_conflict | output | 1 | More than one bus driver is active |
| seq_busy | output | 1 | Sequencer is running |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
Each ALU function is run by hand-gated three-step sequences on operand pairs that differ in carry, borrow and bit overlap. The results show whether the A input really comes from Y and the B input from the bus, because subtraction and NOT give different values when the operands are swapped. Multiple-driver patterns mix two registers with each other, and Z with the external port. They confirm that the flag rises and that nothing is written. The sequencer is driven with every opcode, with a destination equal to a source, and with conflicting stray gating and a second start while it is busy. These runs separate a design that lets outside gating through from one that ignores it, and they pin down the exact cycle of `seq_done`.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int NREG = 8,
  parameter int W    = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] reg_oe,
  input  logic [NREG-1:0] reg_ie,
  input  logic            y_ie,
  input  logic            z_oe,
  input  logic            z_ie,
  input  logic [5:0]      alu_sel,
  input  logic            ext_oe,
  input  logic [W-1:0]    ext_data,
  input  logic            seq_start,
  input  logic [2:0]      seq_op,
  input  logic [IW-1:0]   seq_a,
  input  logic [IW-1:0]   seq_b,
  input  logic [IW-1:0]   seq_dst,
  output logic [W-1:0]    bus,
  output logic            bus_conflict,
  output logic            seq_busy,
  output logic            seq_done
);

  typedef enum logic [1:0] {ST_IDLE, ST_A, ST_B, ST_W} st_t;

  st_t             state;
  logic [2:0]      op_q;
  logic [IW-1:0]   a_q, b_q, d_q;
  logic [W-1:0]    rf [NREG];
  logic [W-1:0]    y_q, z_q, alu_res;

  logic [NREG-1:0] oe_e, ie_e;
  logic            y_e, zo_e, zi_e, ext_e;
  logic [5:0]      sel_e;

  assign seq_busy = (state != ST_IDLE);

  always_comb begin
    oe_e  = reg_oe;
    ie_e  = reg_ie;
    y_e   = y_ie;
    zo_e  = z_oe;
    zi_e  = z_ie;
    sel_e = alu_sel;
    ext_e = ext_oe;
    if (seq_busy) begin
      oe_e  = '0;
      ie_e  = '0;
      y_e   = 1'b0;
      zo_e  = 1'b0;
      zi_e  = 1'b0;
      sel_e = '0;
      ext_e = 1'b0;
      case (state)
        ST_A: begin
          oe_e[a_q] = 1'b1;
          y_e       = 1'b1;
        end
        ST_B: begin
          oe_e[b_q] = 1'b1;
          zi_e      = 1'b1;
          sel_e     = 6'(7'd1 << op_q);
        end
        ST_W: begin
          zo_e      = 1'b1;
          ie_e[d_q] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign bus_conflict = ($countones({ext_e, zo_e, oe_e}) > 1);

  always_comb begin
    bus = '0;
    if (!bus_conflict) begin
      for (int i = 0; i < NREG; i++)
        if (oe_e[i]) bus = rf[i];
      if (zo_e)  bus = z_q;
      if (ext_e) bus = ext_data;
    end
  end

  always_comb begin
    if      (sel_e[0]) alu_res = y_q + bus;
    else if (sel_e[1]) alu_res = y_q - bus;
    else if (sel_e[2]) alu_res = y_q & bus;
    else if (sel_e[3]) alu_res = y_q | bus;
    else if (sel_e[4]) alu_res = ~bus;
    else if (sel_e[5]) alu_res = y_q ^ bus;
    else               alu_res = bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (!bus_conflict) begin
      for (int i = 0; i < NREG; i++)
        if (ie_e[i]) rf[i] <= bus;
      if (y_e)  y_q <= bus;
      if (zi_e) z_q <= alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      d_q      <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= (state == ST_W);
      case (state)
        ST_IDLE: if (seq_start) begin
          state <= ST_A;
          op_q  <= seq_op;
          a_q   <= seq_a;
          b_q   <= seq_b;
          d_q   <= seq_dst;
        end
        ST_A:    state <= ST_B;
        ST_B:    state <= ST_W;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_no_load_on_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    bus_conflict |=> $stable(y_q) && $stable(z_q));

  a_r5_y_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (y_e && !bus_conflict) |=> (y_q == $past(bus)));

  a_r6_z_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!zi_e || bus_conflict) |=> $stable(z_q));

  a_r6_z_takes_alu: assert property (@(posedge clk) disable iff (!rst_n)
    (zi_e && !bus_conflict) |=> (z_q == $past(alu_res)));

  a_r8_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !seq_busy) |=> seq_busy);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seq_busy);

  a_r9_busy_no_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !bus_conflict);

endmodule

// File: tb/sbus_datapath_bench.sv
module sbus_datapath_bench;
  localparam int NREG = 8;
  localparam int W    = 16;
  localparam int IW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREG-1:0] reg_oe = '0, reg_ie = '0;
  logic            y_ie = 0, z_oe = 0, z_ie = 0, ext_oe = 0, seq_start = 0;
  logic [5:0]      alu_sel = '0;
  logic [W-1:0]    ext_data = '0;
  logic [2:0]      seq_op = '0;
  logic [IW-1:0]   seq_a = '0, seq_b = '0, seq_dst = '0;
  logic [W-1:0]    bus;
  logic            bus_conflict, seq_busy, seq_done;

  int nchk = 0, nfail = 0;
  logic [W-1:0] mdl [NREG];

  always #2.5 clk = ~clk;

  sbus_datapath #(.NREG(NREG), .W(W)) u_sbus_datapath (
    .clk, .rst_n, .reg_oe, .reg_ie, .y_ie, .z_oe, .z_ie, .alu_sel,
    .ext_oe, .ext_data, .seq_start, .seq_op, .seq_a, .seq_b, .seq_dst,
    .bus, .bus_conflict, .seq_busy, .seq_done);

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fn(int op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return ~b;
      5: return a ^ b;
      default: return b;
    endcase
  endfunction

  task automatic idle_in();
    reg_oe = '0; reg_ie = '0; y_ie = 0; z_oe = 0; z_ie = 0;
    alu_sel = '0; ext_oe = 0; seq_start = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle_in();
  endtask

  task automatic rd(int i, output logic [W-1:0] v);
    reg_oe = '0; reg_oe[i] = 1'b1; #0.5;
    v = bus; reg_oe = '0; #0.5;
  endtask

  task automatic put(int i, logic [W-1:0] v);
    ext_oe = 1; ext_data = v; reg_ie[i] = 1'b1;
    tick();
    mdl[i] = v;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R1 idle bus", bus, '0);
    chk("R1 busy", W'(seq_busy), '0);
    chk("R1 done", W'(seq_done), '0);
    for (int i = 0; i < NREG; i++) begin
      rd(i, v); chk("R1 reg", v, '0);
      mdl[i] = '0;
    end
    z_oe = 1; #0.5; chk("R1 Z", bus, '0); z_oe = 0; #0.5;
  endtask

  task automatic t_move();
    logic [W-1:0] v;
    for (int i = 0; i < NREG; i++) put(i, W'(16'h1111 * i + 3));
    for (int i = 0; i < NREG; i++) begin rd(i, v); chk("R3 ext load", v, mdl[i]); end
    reg_oe[1] = 1; reg_ie[4] = 1; reg_ie[6] = 1;
    tick(); mdl[4] = mdl[1]; mdl[6] = mdl[1];
    rd(4, v); chk("R2 move", v, mdl[1]);
    rd(6, v); chk("R2 broadcast", v, mdl[1]);
    rd(1, v); chk("R2 source kept", v, mdl[1]);
  endtask

  task automatic t_conflict();
    logic [W-1:0] v;
    reg_oe[2] = 1; reg_oe[3] = 1; reg_ie[7] = 1; y_ie = 1; #0.5;
    chk("R4 flag", W'(bus_conflict), 1);
    chk("R4 bus zero", bus, '0);
    tick();
    rd(7, v); chk("R4 no load", v, mdl[7]);
    z_oe = 1; ext_oe = 1; ext_data = 16'hBEEF; reg_ie[0] = 1; z_ie = 1; #0.5;
    chk("R4 Z+ext flag", W'(bus_conflict), 1);
    tick();
    rd(0, v); chk("R4 no load 2", v, mdl[0]);
    z_oe = 1; #0.5; chk("R4 Z kept", bus, '0); z_oe = 0; #0.5;
  endtask

  task automatic three_step(logic [5:0] sel, int sa, int sb, int d, logic [W-1:0] exp, string tag);
    logic [W-1:0] v;
    reg_oe[sa] = 1; y_ie = 1; tick();
    reg_oe[sb] = 1; alu_sel = sel; z_ie = 1; tick();
    z_oe = 1; reg_ie[d] = 1; tick();
    mdl[d] = exp;
    rd(d, v); chk(tag, v, exp);
  endtask

  task automatic t_alu();
    logic [W-1:0] v;
    put(1, 16'hFFF0); put(2, 16'h0025);
    three_step(6'b000001, 1, 2, 3, 16'h0015, "R7 add carry");
    three_step(6'b000010, 1, 2, 3, 16'hFFCB, "R5 sub A-B");
    three_step(6'b000010, 2, 1, 3, 16'h0035, "R5 sub swapped");
    three_step(6'b000100, 1, 2, 3, 16'h0020, "R7 and");
    three_step(6'b001000, 1, 2, 3, 16'hFFF5, "R7 or");
    three_step(6'b010000, 1, 2, 3, 16'hFFDA, "R7 not B");
    three_step(6'b100000, 1, 2, 3, 16'hFFD5, "R7 xor");
    three_step(6'b000000, 1, 2, 3, 16'h0025, "R6 none passes B");
    three_step(6'b100001, 1, 2, 3, 16'h0015, "R6 lowest bit wins");
    reg_oe[2] = 1; alu_sel = 6'b000001; tick();
    z_oe = 1; #0.5; chk("R6 Z held without z_ie", bus, 16'h0015); z_oe = 0; #0.5;
  endtask

  task automatic t_seq(int op, int sa, int sb, int d, bit junk);
    logic [W-1:0] v, exp;
    exp = fn(op, mdl[sa], mdl[sb]);
    seq_start = 1; seq_op = 3'(op); seq_a = IW'(sa); seq_b = IW'(sb); seq_dst = IW'(d);
    tick();
    chk("R8 busy after start", W'(seq_busy), 1);
    for (int k = 0; k < 2; k++) begin
      if (junk) begin
        reg_oe = '1; reg_ie = '1; z_oe = 1; ext_oe = 1; ext_data = 16'hDEAD;
        y_ie = 1; seq_start = 1; seq_dst = IW'(d ^ 1); #0.5;
        chk("R9 no conflict while busy", W'(bus_conflict), 0);
      end
      tick();
      chk("R8 done not early", W'(seq_done), 0);
    end
    tick();
    chk("R8 done on time", W'(seq_done), 1);
    chk("R8 idle at done", W'(seq_busy), 0);
    mdl[d] = exp;
    rd(d, v); chk("R8 result", v, exp);
    if (junk) begin rd(d ^ 1, v); chk("R9 junk ignored", v, mdl[d ^ 1]); end
    tick();
    chk("R8 done one cycle", W'(seq_done), 0);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_move();
    t_conflict();
    t_alu();
    put(5, 16'h1234); put(6, 16'h0F0F);
    for (int op = 0; op < 8; op++) t_seq(op, 5, 6, 7, 1'b0);
    t_seq(0, 5, 5, 5, 1'b0);
    chk("R10 dst equals source", mdl[5], 16'h2468);
    t_seq(1, 6, 5, 6, 1'b0);
    t_seq(5, 5, 6, 2, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule